// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block steps the processor side of the exchange with an attached coprocessor when a coprocessor instruction issues. It handles two kinds of instruction: register transfers, which move one word between core and coprocessor, and memory transfers, which move a run of words between memory and the coprocessor. It first checks that the addressed coprocessor exists. It then offers the instruction to the coprocessor, waits out any busy replies, and may abandon the wait when an interrupt is pending. For a memory transfer it produces the word addresses until the coprocessor stops asking for more words, and it stops early if memory aborts.

An instruction starts with a one-cycle `start` strobe carrying the instruction word and the base address. The coprocessor answers each phase code in the same cycle on `copResp`. Memory answers each address in the same cycle on `memAbort`. The block ends every instruction with a one-cycle `done` pulse. The exception outcome, the base-writeback enable and any word read from the coprocessor are valid during that pulse.

Instruction fields used: bits [11:8] give the coprocessor number, bit 21 requests base writeback, and bit 20 marks a read from the coprocessor. Bits [27:25] equal to 3'b110 select a memory transfer; any other value selects a register transfer.

Top module: `cop_seq`

## Requirements
- R1: If the bit of `cpPresent` indexed by instruction bits [11:8] is 0, then `done` is high with `excSel`=1 (undefined) and `undefReq` high in the cycle after `start`. No phase code other than 0 is issued.
- R2: The phase codes are 0 none, 1 first, 2 busy, 3 interrupt, 4 transfer, 5 data. The response codes are 0 done, 1 busy, 2 can't, 3 increment. An accepted instruction shows phase 1 in the cycle after `start`. Each busy reply to phase 1 or 2 is followed by exactly one cycle of phase 0 and then phase 2.
- R3: If an interrupt is pending in the idle cycle of a busy wait, the next cycle shows phase 3. The cycle after that ends the instruction with no transfer or data phase.
- R4: The pending interrupt chosen is `rstReq` first, then `fiqReq` when `fiqMask` is 0, then `irqReq` when `irqMask` is 0. At `done`, `excSel` is 3 for reset, 4 for FIQ and 5 for IRQ. Masked lines do not abandon the wait.
- R5: A can't reply to phase 1 or 2 ends the instruction in the next cycle with `excSel`=1 and `undefReq` high.
- R6: A memory transfer shows phase 4 for one cycle after acceptance. It then shows phase 5 with `memValid` high and `memAddr` equal to `baseAddr`. The address rises by 4 for each further word while the reply to phase 5 is increment. A done reply ends the transfer.
- R7: `memAbort` high with `memValid` stops the transfer. The next cycle has `done` high, `excSel`=2 and `abortReq` high.
- R8: `wbEn` is high at `done` only for a memory transfer with bit 21 set that ended without exception, or that ended in an abort while `lateAbortMode` is 1.
- R9: `done` is high for exactly one cycle. The next cycle shows phase 0 with `done` low.
- R10: For a register read that completes, `rdData` at `done` holds the `copRdData` value presented during the data phase. In every other case, including an abandoned read, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction issue strobe |
| instrWord | input | 32 | Instruction word |
| baseAddr | input | 32 | Base address for memory transfers |
| cpPresent | input | 16 | One bit per coprocessor number |
| copResp | input | 2 | Coprocessor reply code |
| copRdData | input | 32 | Word from the coprocessor for register reads |
| rstReq | input | 1 | Pending reset |
| fiqReq | input | 1 | Fast interrupt request |
| fiqMask | input | 1 | Fast interrupt mask |
| irqReq | input | 1 | Interrupt request |
| irqMask | input | 1 | Interrupt mask |
| memAbort | input | 1 | Memory abort for the current word |
| lateAbortMode | input | 1 | Late-abort mode select |
| copPhase | output | 3 | Phase code to the coprocessor |
| memValid | output | 1 | Word address valid |
| memAddr | output | 32 | Word address |
| wbEn | output | 1 | Base writeback enable (at done) |
| undefReq | output | 1 | Undefined-instruction request (at done) |
| abortReq | output | 1 | Abort request (at done) |
| excSel | output | 3 | Exception vector select (at done) |
| done | output | 1 | End-of-instruction pulse |
| rdData | output | 32 | Register read data (at done) |

## Verification
Counting from the edge that samples `start`, with b busy replies and n words, `done` is due in these cycles:
- after 1 cycle for an absent coprocessor;
- after 2+2b cycles for a can't reply;
- after 4 cycles when an interrupt abandons the first busy wait;
- after 3+2b cycles for a register transfer;
- after 3+2b+n cycles for a memory transfer;
- after 4+2b+j cycles for an abort on word j.

The bench builds each scenario, computes this latency and the expected outcome, and counts cycles at falling edges until `done`. It checks that the pulse appears in the predicted cycle. It answers each phase at the falling edge after the phase appears, so every reply is sampled at the next rising edge. It checks each `memAddr` in the cycle its word is shown.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_XFER  = 3'd4,
    PH_DATA  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    RSP_DONE = 2'd0,
    RSP_BUSY = 2'd1,
    RSP_CANT = 2'd2,
    RSP_INC  = 2'd3
  } resp_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_ABORT = 3'd2,
    EXC_RESET = 3'd3,
    EXC_FIQ   = 3'd4,
    EXC_IRQ   = 3'd5
  } exc_e;

  typedef struct packed {
    logic latch;
    logic step;
    logic capRd;
    logic setExc;
    exc_e excCode;
  } strobe_t;

endpackage

// File: rtl/cop_seq_ctrl.sv
module cop_seq_ctrl
  import cop_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cpOk,
  input  logic    memClass,
  input  logic    isRead,
  input  resp_e   resp,
  input  logic    memAbort,
  input  logic    rstReq,
  input  logic    fiqReq,
  input  logic    fiqMask,
  input  logic    irqReq,
  input  logic    irqMask,
  output phase_e  phase,
  output logic    memValid,
  output logic    done,
  output strobe_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSYQ, S_INTR, S_XFER, S_DATA, S_FIN
  } state_e;

  state_e state, stateNxt;
  logic   intrPend;
  exc_e   intrCode;

  always_comb begin
    intrPend = 1'b1;
    intrCode = EXC_NONE;
    if (rstReq)                  intrCode = EXC_RESET;
    else if (fiqReq && !fiqMask) intrCode = EXC_FIQ;
    else if (irqReq && !irqMask) intrCode = EXC_IRQ;
    else                         intrPend = 1'b0;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    phase    = PH_NONE;
    memValid = 1'b0;
    done     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          if (!cpOk) begin
            strb.setExc  = 1'b1;
            strb.excCode = EXC_UNDEF;
            stateNxt     = S_FIN;
          end else begin
            stateNxt = S_FIRST;
          end
        end
      end
      S_FIRST, S_BUSYQ: begin
        phase = (state == S_FIRST) ? PH_FIRST : PH_BUSY;
        unique case (resp)
          RSP_BUSY: stateNxt = S_WAIT;
          RSP_CANT: begin
            strb.setExc  = 1'b1;
            strb.excCode = EXC_UNDEF;
            stateNxt     = S_FIN;
          end
          default:  stateNxt = memClass ? S_XFER : S_DATA;
        endcase
      end
      S_WAIT: begin
        if (intrPend) begin
          strb.setExc  = 1'b1;
          strb.excCode = intrCode;
          stateNxt     = S_INTR;
        end else begin
          stateNxt = S_BUSYQ;
        end
      end
      S_INTR: begin
        phase    = PH_INTR;
        stateNxt = S_FIN;
      end
      S_XFER: begin
        phase    = PH_XFER;
        stateNxt = S_DATA;
      end
      S_DATA: begin
        phase = PH_DATA;
        if (memClass) begin
          memValid = 1'b1;
          if (memAbort) begin
            strb.setExc  = 1'b1;
            strb.excCode = EXC_ABORT;
            stateNxt     = S_FIN;
          end else if (resp == RSP_INC) begin
            strb.step = 1'b1;
          end else begin
            stateNxt = S_FIN;
          end
        end else begin
          strb.capRd = isRead;
          stateNxt   = S_FIN;
        end
      end
      S_FIN: begin
        done     = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  AST_ABSENT_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && !cpOk) |=> done); // R1
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_FIRST || phase == PH_BUSY) && resp == RSP_BUSY) |=> (phase == PH_NONE)); // R2
  AST_INTR_END: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_INTR) |=> (done && !memValid)); // R3
  AST_INC_CONT: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAbort && resp == RSP_INC) |=> memValid); // R6
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memAbort) |=> (done && !memValid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && phase == PH_NONE)); // R9

endmodule

// File: rtl/cop_seq_dpath.sv
module cop_seq_dpath
  import cop_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int WORD_BYTES = 4,
  parameter int WB_BIT     = 21,
  parameter int DIR_BIT    = 20,
  parameter int CLASS_LSB  = 25,
  parameter int CLASS_W    = 3,
  parameter logic [CLASS_W-1:0] MEM_CLASS = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [DATA_W-1:0]  copRdData,
  input  logic               done,
  input  logic               lateAbortMode,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  rdData,
  output exc_e               excQ,
  output logic               memClass,
  output logic               isRead,
  output logic               wbEn
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic wbReqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      rdData   <= '0;
      excQ     <= EXC_NONE;
      memClass <= 1'b0;
      isRead   <= 1'b0;
      wbReqQ   <= 1'b0;
    end else if (strb.latch) begin
      memAddr  <= baseAddr;
      rdData   <= '0;
      excQ     <= strb.setExc ? strb.excCode : EXC_NONE;
      memClass <= (instrWord[CLASS_LSB +: CLASS_W] == MEM_CLASS);
      isRead   <= instrWord[DIR_BIT];
      wbReqQ   <= instrWord[WB_BIT];
    end else begin
      if (strb.step)   memAddr <= memAddr + STEP;
      if (strb.capRd)  rdData  <= copRdData;
      if (strb.setExc) excQ    <= strb.excCode;
    end
  end

  assign wbEn = done && memClass && wbReqQ &&
                (excQ == EXC_NONE || (excQ == EXC_ABORT && lateAbortMode));

  AST_WB_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (excQ == EXC_NONE || excQ == EXC_ABORT)); // R8
  AST_RD_ZERO_ABANDON: assert property (@(posedge clk) disable iff (!rstN)
    (done && (excQ == EXC_RESET || excQ == EXC_FIQ || excQ == EXC_IRQ)) |-> (rdData == '0)); // R10

endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int NUM_CP  = 16,
  parameter int CP_LSB  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [NUM_CP-1:0]  cpPresent,
  input  logic [1:0]         copResp,
  input  logic [DATA_W-1:0]  copRdData,
  input  logic               rstReq,
  input  logic               fiqReq,
  input  logic               fiqMask,
  input  logic               irqReq,
  input  logic               irqMask,
  input  logic               memAbort,
  input  logic               lateAbortMode,
  output logic [2:0]         copPhase,
  output logic               memValid,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               wbEn,
  output logic               undefReq,
  output logic               abortReq,
  output logic [2:0]         excSel,
  output logic               done,
  output logic [DATA_W-1:0]  rdData
);

  localparam int CP_W = (NUM_CP > 1) ? $clog2(NUM_CP) : 1;

  strobe_t strb;
  phase_e  phase;
  exc_e    excQ;
  logic    memClass, isRead, cpOk;

  assign cpOk = cpPresent[instrWord[CP_LSB +: CP_W]];

  cop_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cpOk(cpOk),
    .memClass(memClass), .isRead(isRead), .resp(resp_e'(copResp)),
    .memAbort(memAbort), .rstReq(rstReq), .fiqReq(fiqReq), .fiqMask(fiqMask),
    .irqReq(irqReq), .irqMask(irqMask), .phase(phase), .memValid(memValid),
    .done(done), .strb(strb)
  );

  cop_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSTR_W(INSTR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .instrWord(instrWord),
    .baseAddr(baseAddr), .copRdData(copRdData), .done(done),
    .lateAbortMode(lateAbortMode), .memAddr(memAddr), .rdData(rdData),
    .excQ(excQ), .memClass(memClass), .isRead(isRead), .wbEn(wbEn)
  );

  assign copPhase = phase;
  assign excSel   = done ? excQ : EXC_NONE;
  assign undefReq = done && (excQ == EXC_UNDEF);
  assign abortReq = done && (excQ == EXC_ABORT);

endmodule

// File: tb/test_cop_seq.sv
`timescale 1ns/1ps
module test_cop_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instrWord = '0, baseAddr = '0, copRdData = '0;
  logic [15:0] cpPresent = '0;
  logic [1:0]  copResp = 2'd0;
  logic        rstReq = 0, fiqReq = 0, fiqMask = 0, irqReq = 0, irqMask = 0;
  logic        memAbort = 0, lateAbortMode = 0;
  logic [2:0]  copPhase, excSel;
  logic        memValid, wbEn, undefReq, abortReq, done;
  logic [31:0] memAddr, rdData;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cop_seq i_cop_seq (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .baseAddr(baseAddr), .cpPresent(cpPresent), .copResp(copResp),
    .copRdData(copRdData), .rstReq(rstReq), .fiqReq(fiqReq), .fiqMask(fiqMask),
    .irqReq(irqReq), .irqMask(irqMask), .memAbort(memAbort),
    .lateAbortMode(lateAbortMode), .copPhase(copPhase), .memValid(memValid),
    .memAddr(memAddr), .wbEn(wbEn), .undefReq(undefReq), .abortReq(abortReq),
    .excSel(excSel), .done(done), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int expExc(bit pres, bit mem, int busyN, bit cant, int nW, int abIdx,
                                bit rq, bit fq, bit fm, bit iq, bit im);
    if (!pres) return 1;
    if (busyN > 0 && rq) return 3;
    if (busyN > 0 && fq && !fm) return 4;
    if (busyN > 0 && iq && !im) return 5;
    if (cant) return 1;
    if (mem && abIdx >= 0 && abIdx < nW) return 2;
    return 0;
  endfunction

  function automatic int expLat(bit pres, bit mem, int busyN, bit cant, int nW, int abIdx, int exc);
    if (!pres) return 1;
    if (exc >= 3) return 4;
    if (cant) return 2 + 2*busyN;
    if (!mem) return 3 + 2*busyN;
    if (exc == 2) return 4 + 2*busyN + abIdx;
    return 3 + 2*busyN + nW;
  endfunction

  task automatic runScn(input bit pres, input bit mem, input bit rd, input bit wb,
                        input bit late, input int busyN, input bit cant, input int nW,
                        input int abIdx, input bit rq, input bit fq, input bit fm,
                        input bit iq, input bit im);
    int exc, lat, cyc, busyLeft, wIdx, intrSeen, firstSeen, expW;
    bit prevBusy, expWb;
    logic [31:0] base, rdVal;
    logic [3:0]  cpn;
    exc   = expExc(pres, mem, busyN, cant, nW, abIdx, rq, fq, fm, iq, im);
    lat   = expLat(pres, mem, busyN, cant, nW, abIdx, exc);
    expWb = mem && wb && (exc == 0 || (exc == 2 && late));
    expW  = (!pres || exc == 1 || exc >= 3 || !mem) ? 0 : ((exc == 2) ? abIdx + 1 : nW);
    base  = $urandom() & 32'hFFFF_FFFC;
    rdVal = $urandom();
    cpn   = 4'($urandom());
    @(negedge clk);
    cpPresent = 16'($urandom());
    cpPresent[cpn] = pres;
    instrWord = $urandom();
    instrWord[27:25] = mem ? 3'b110 : 3'b111;
    instrWord[11:8] = cpn;
    instrWord[21] = wb;
    instrWord[20] = rd;
    baseAddr = base; copRdData = rdVal; lateAbortMode = late;
    rstReq = rq; fiqReq = fq; fiqMask = fm; irqReq = iq; irqMask = im;
    copResp = 2'd0; memAbort = 0; start = 1'b1;
    busyLeft = busyN; wIdx = 0; intrSeen = 0; firstSeen = 0; prevBusy = 0;
    cyc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (cyc > 300) begin
        chk(0, "R9 watchdog", cyc, lat);
        break;
      end
      if (prevBusy) chk(copPhase == 3'd0, "R2 idle after busy", copPhase, 0);
      prevBusy = 0;
      if (copPhase == 3'd1) firstSeen++;
      if (copPhase == 3'd3) intrSeen++;
      copResp = 2'd0; memAbort = 0;
      if (copPhase == 3'd1 || copPhase == 3'd2) begin
        if (busyLeft > 0) begin
          copResp = 2'd1; busyLeft--; prevBusy = 1;
        end else begin
          copResp = cant ? 2'd2 : (mem ? 2'd3 : 2'd0);
        end
      end else if (memValid) begin
        chk(copPhase == 3'd5, "R6 data phase", copPhase, 5);
        chk(memAddr == base + 32'(4*wIdx), "R6 address", memAddr, base + 32'(4*wIdx));
        copResp  = (wIdx < nW - 1) ? 2'd3 : 2'd0;
        memAbort = (wIdx == abIdx);
        wIdx++;
      end
      if (done) begin
        chk(cyc == lat, "R1/R3/R5/R6/R7 latency", cyc, lat);
        chk(excSel == 3'(exc), "R4 excSel", excSel, exc);
        chk(undefReq == (exc == 1), "R5 undefReq", undefReq, exc == 1);
        chk(abortReq == (exc == 2), "R7 abortReq", abortReq, exc == 2);
        chk(wbEn == expWb, "R8 wbEn", wbEn, expWb);
        chk(rdData == ((!mem && rd && exc == 0) ? rdVal : 32'd0), "R10 rdData",
            rdData, (!mem && rd && exc == 0) ? rdVal : 32'd0);
        chk(wIdx == expW, "R6 word count", wIdx, expW);
        chk(intrSeen == ((exc >= 3) ? 1 : 0), "R3 interrupt phase", intrSeen, exc >= 3);
        chk(firstSeen == (pres ? 1 : 0), "R1/R2 first phase", firstSeen, pres);
        break;
      end
    end
    @(negedge clk);
    chk(!done && copPhase == 3'd0, "R9 single done", done, 0);
    rstReq = 0; fiqReq = 0; irqReq = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(copPhase == 0 && !done && !memValid && excSel == 0 && !wbEn && rdData == 0,
        "R9 reset state", {copPhase, done, memValid}, 0);
    // directed corners
    runScn(0, 1, 0, 1, 0, 0, 0, 3, -1, 0, 0, 0, 0, 0);  // R1 absent
    runScn(1, 0, 1, 0, 0, 2, 0, 1, -1, 0, 0, 0, 0, 0);  // R2 R10 busy then read
    runScn(1, 0, 1, 0, 0, 1, 0, 1, -1, 0, 0, 0, 1, 0);  // R3 R10 abandoned read
    runScn(1, 1, 0, 1, 0, 2, 0, 3, -1, 1, 1, 0, 1, 0);  // R4 reset wins
    runScn(1, 1, 0, 1, 0, 2, 0, 3, -1, 0, 1, 0, 1, 0);  // R4 fiq over irq
    runScn(1, 1, 0, 1, 0, 2, 0, 3, -1, 0, 1, 1, 1, 0);  // R4 fiq masked -> irq
    runScn(1, 1, 0, 1, 0, 2, 0, 2, -1, 0, 1, 1, 1, 1);  // R4 all masked, completes
    runScn(1, 1, 0, 1, 0, 1, 1, 3, -1, 0, 0, 0, 0, 0);  // R5 cant
    runScn(1, 1, 0, 1, 0, 0, 0, 5, -1, 0, 0, 0, 0, 0);  // R6 five words
    runScn(1, 1, 0, 1, 0, 0, 0, 4, 2, 0, 0, 0, 0, 0);   // R7 R8 abort, early mode
    runScn(1, 1, 0, 1, 1, 0, 0, 4, 0, 0, 0, 0, 0, 0);   // R7 R8 abort, late mode
    runScn(1, 1, 0, 0, 1, 0, 0, 2, -1, 0, 0, 0, 0, 0);  // R8 no wb request
    // constrained random
    for (int i = 0; i < 60; i++) begin
      int nw;
      int ab;
      nw = 1 + int'($urandom_range(5));
      ab = ($urandom_range(3) == 0) ? int'($urandom_range(nw - 1)) : -1;
      runScn($urandom_range(7) != 0, 1'($urandom()), 1'($urandom()), 1'($urandom()),
             1'($urandom()), int'($urandom_range(3)), $urandom_range(5) == 0, nw, ab,
             $urandom_range(7) == 0, 1'($urandom()), 1'($urandom()), 1'($urandom()),
             1'($urandom()));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule